// File: doc/BRIEF.md
# Ethernet Transmit Serializer and Framer

This block turns a stream of packet bytes into a serial, NRZ transmit bit stream with a qualifying enable, one bit per clock. A frame begins with a start pulse. The block then sends an alternating one/zero preamble and a two-bit sync mark. It then takes bytes from a first-word-fall-through byte queue and sends each one least significant bit first. While the data bits go out, they are also fed into a 32-bit CRC. When the byte flagged as last has been sent, the CRC register is shifted straight out as the frame check sequence.

A collision input cuts the frame short at any point after the start. The bit already being sent completes, and then 32 ones go out as a jam. A byte queue that runs dry at a byte boundary also ends the frame with the jam, and raises a sticky underrun flag. The block never pads short frames. Encoding to line symbols, retry timing and the memory-side transfer logic belong to neighbouring blocks.

Top module: `eth_tx_framer`

## Requirements
- R1: After synchronous reset, `txen`, `txd`, `frame_done`, `underrun` and `byte_pop` are all low and no bits are sent.
- R2: When `frame_start` is sampled high in idle, `txen` rises one clock later. The first bits are 62 preamble bits alternating 1,0,1,0,… (starting with 1), then the sync bits 1,1.
- R3: After the sync bits, each byte from `byte_data` is sent bit 0 first. `byte_pop` pulses once per byte, and only while `byte_empty` is low. The byte presented with `byte_last` high is the final data byte. No pad bits are added, so a clean frame of N bytes is exactly 64 + 8N + 32 bits long.
- R4: The FCS uses generator polynomial 0x04C11DB7 and a register preset to all ones. It covers only the data bits. The register's top bit is sent first, complemented. Read as a 32-bit word whose bit 0 went out first, the FCS of the ASCII bytes "123456789" is 0xCBF43926.
- R5: If `collision` is high in a clock when the frame is in preamble, sync, data or FCS, the bit of that clock is the last normal bit. Exactly 32 ones follow, then the frame ends. `collision` has no effect during the jam itself.
- R6: If `byte_empty` is high when a new byte is needed (after sync, or after a byte that was not the last), `underrun` goes high and 32 ones follow the bit just sent. `underrun` stays high until the next accepted start.
- R7: `txen` is high without a gap from the first preamble bit to the last FCS or jam bit. `frame_done` is a one-clock pulse in the first clock `txen` is low again.
- R8: `frame_start` has no effect while a frame is in progress, and `collision` has no effect while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transmit bit clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_start | input | 1 | Begin a frame (sampled in idle only) |
| byte_data | input | 8 | Head byte of the byte queue |
| byte_empty | input | 1 | Byte queue has no byte available |
| byte_last | input | 1 | Head byte is the last of the packet |
| byte_pop | output | 1 | Consume the head byte this clock |
| collision | input | 1 | Collision seen on the medium |
| txen | output | 1 | Transmit enable, qualifies `txd` |
| txd | output | 1 | Serial NRZ transmit data |
| frame_done | output | 1 | One-clock pulse after the last bit |
| underrun | output | 1 | Frame ended because the queue ran dry |

## Verification
The FCS is checked against the well-known value for the nine ASCII digits. This separates a correct polynomial, preset and output inversion from a near miss. Frames of one zero byte, four 0xFF bytes, and longer counting and mixed patterns catch errors in bit order, byte-boundary handling and padding. Collisions are placed in the preamble, in the data and in the FCS, and underruns before the first byte and in mid-packet. Each one must end the frame with exactly 32 ones after the right bit. A second start in mid-frame and a collision pulse while idle must leave the bit stream unchanged.

// File: rtl/eth_tx_pkg.sv
package eth_tx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_PRE  = 3'd1,
    ST_SYNC = 3'd2,
    ST_DATA = 3'd3,
    ST_FCS  = 3'd4,
    ST_JAM  = 3'd5
  } tx_state_t;

  function automatic int max_of(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/eth_tx_crc.sv
module eth_tx_crc #(
  parameter int          CRC_W    = 32,
  parameter logic [31:0] CRC_POLY = 32'h04C11DB7
) (
  input  logic clk,
  input  logic rst,
  input  logic init,
  input  logic feed,
  input  logic din,
  input  logic shift,
  output logic msb
);

  localparam logic [CRC_W-1:0] POLY = CRC_POLY[CRC_W-1:0];

  logic [CRC_W-1:0] crc_q;
  logic             fb;

  assign fb  = crc_q[CRC_W-1] ^ din;
  assign msb = crc_q[CRC_W-1];

  always_ff @(posedge clk) begin
    if (rst || init) begin
      crc_q <= '1;
    end else if (feed) begin
      crc_q <= {crc_q[CRC_W-2:0], 1'b0} ^ (fb ? POLY : '0);
    end else if (shift) begin
      crc_q <= {crc_q[CRC_W-2:0], 1'b1};
    end
  end

endmodule

// File: rtl/eth_tx_shifter.sv
module eth_tx_shifter #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic              shift,
  input  logic [BYTE_W-1:0] din,
  input  logic              din_last,
  output logic              lsb,
  output logic              is_last
);

  logic [BYTE_W-1:0] sh_q;
  logic              last_q;

  assign lsb     = sh_q[0];
  assign is_last = last_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_q   <= '0;
      last_q <= 1'b0;
    end else if (load) begin
      sh_q   <= din;
      last_q <= din_last;
    end else if (shift) begin
      sh_q   <= {1'b0, sh_q[BYTE_W-1:1]};
    end
  end

endmodule

// File: rtl/eth_tx_ctrl.sv
module eth_tx_ctrl
  import eth_tx_pkg::*;
#(
  parameter int PRE_BITS = 62,
  parameter int JAM_BITS = 32,
  parameter int CRC_W    = 32,
  parameter int BYTE_W   = 8
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      frame_start,
  input  logic      collision,
  input  logic      byte_empty,
  input  logic      last_byte,
  output tx_state_t state,
  output logic      cnt_lsb,
  output logic      byte_pop,
  output logic      crc_init,
  output logic      crc_feed,
  output logic      crc_shift,
  output logic      sh_shift,
  output logic      underrun_set
);

  localparam int SYNC_BITS = 2;
  localparam int MAXC      = max_of(max_of(PRE_BITS, JAM_BITS),
                                    max_of(max_of(CRC_W, BYTE_W), SYNC_BITS));
  localparam int CNT_W     = $clog2(MAXC);

  localparam logic [CNT_W-1:0] PRE_END  = CNT_W'(PRE_BITS - 1);
  localparam logic [CNT_W-1:0] SYNC_END = CNT_W'(SYNC_BITS - 1);
  localparam logic [CNT_W-1:0] BYTE_END = CNT_W'(BYTE_W - 1);
  localparam logic [CNT_W-1:0] FCS_END  = CNT_W'(CRC_W - 1);
  localparam logic [CNT_W-1:0] JAM_END  = CNT_W'(JAM_BITS - 1);

  tx_state_t        st_q, st_n;
  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic             need_byte;
  logic             coll_hit;

  assign state   = st_q;
  assign cnt_lsb = cnt_q[0];

  // A new byte is due at the end of sync, or at the end of a non-final byte.
  assign need_byte = ((st_q == ST_SYNC) && (cnt_q == SYNC_END)) ||
                     ((st_q == ST_DATA) && (cnt_q == BYTE_END) && !last_byte);

  assign coll_hit = collision &&
                    ((st_q == ST_PRE) || (st_q == ST_SYNC) ||
                     (st_q == ST_DATA) || (st_q == ST_FCS));

  assign byte_pop  = need_byte && !byte_empty && !coll_hit;
  assign crc_init  = (st_q == ST_IDLE) && frame_start;
  assign crc_feed  = (st_q == ST_DATA);
  assign crc_shift = (st_q == ST_FCS);
  assign sh_shift  = (st_q == ST_DATA);

  always_comb begin
    st_n         = st_q;
    cnt_n        = cnt_q + 1'b1;
    underrun_set = 1'b0;
    if (coll_hit) begin
      st_n  = ST_JAM;
      cnt_n = '0;
    end else begin
      unique case (st_q)
        ST_IDLE: begin
          cnt_n = '0;
          if (frame_start) st_n = ST_PRE;
        end
        ST_PRE: begin
          if (cnt_q == PRE_END) begin
            st_n  = ST_SYNC;
            cnt_n = '0;
          end
        end
        ST_SYNC: begin
          if (cnt_q == SYNC_END) begin
            cnt_n = '0;
            if (byte_empty) begin
              st_n         = ST_JAM;
              underrun_set = 1'b1;
            end else begin
              st_n = ST_DATA;
            end
          end
        end
        ST_DATA: begin
          if (cnt_q == BYTE_END) begin
            cnt_n = '0;
            if (last_byte) begin
              st_n = ST_FCS;
            end else if (byte_empty) begin
              st_n         = ST_JAM;
              underrun_set = 1'b1;
            end
          end
        end
        ST_FCS: begin
          if (cnt_q == FCS_END) begin
            st_n  = ST_IDLE;
            cnt_n = '0;
          end
        end
        ST_JAM: begin
          if (cnt_q == JAM_END) begin
            st_n  = ST_IDLE;
            cnt_n = '0;
          end
        end
        default: begin
          st_n  = ST_IDLE;
          cnt_n = '0;
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
    end else begin
      st_q  <= st_n;
      cnt_q <= cnt_n;
    end
  end

endmodule

// File: rtl/eth_tx_framer.sv
module eth_tx_framer
  import eth_tx_pkg::*;
#(
  parameter int          PRE_BITS = 62,
  parameter int          JAM_BITS = 32,
  parameter int          CRC_W    = 32,
  parameter logic [31:0] CRC_POLY = 32'h04C11DB7,
  parameter int          BYTE_W   = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              frame_start,
  input  logic [BYTE_W-1:0] byte_data,
  input  logic              byte_empty,
  input  logic              byte_last,
  output logic              byte_pop,
  input  logic              collision,
  output logic              txen,
  output logic              txd,
  output logic              frame_done,
  output logic              underrun
);

  tx_state_t state;
  logic      cnt_lsb;
  logic      crc_init, crc_feed, crc_shift, crc_msb;
  logic      sh_shift, sh_lsb, sh_last;
  logic      underrun_set;
  logic      active, bit_c;
  logic      txen_q, txd_q, done_q, under_q;

  eth_tx_ctrl #(
    .PRE_BITS (PRE_BITS),
    .JAM_BITS (JAM_BITS),
    .CRC_W    (CRC_W),
    .BYTE_W   (BYTE_W)
  ) u_ctrl (
    .clk          (clk),
    .rst          (rst),
    .frame_start  (frame_start),
    .collision    (collision),
    .byte_empty   (byte_empty),
    .last_byte    (sh_last),
    .state        (state),
    .cnt_lsb      (cnt_lsb),
    .byte_pop     (byte_pop),
    .crc_init     (crc_init),
    .crc_feed     (crc_feed),
    .crc_shift    (crc_shift),
    .sh_shift     (sh_shift),
    .underrun_set (underrun_set)
  );

  eth_tx_shifter #(
    .BYTE_W (BYTE_W)
  ) u_shift (
    .clk      (clk),
    .rst      (rst),
    .load     (byte_pop),
    .shift    (sh_shift),
    .din      (byte_data),
    .din_last (byte_last),
    .lsb      (sh_lsb),
    .is_last  (sh_last)
  );

  eth_tx_crc #(
    .CRC_W    (CRC_W),
    .CRC_POLY (CRC_POLY)
  ) u_crc (
    .clk   (clk),
    .rst   (rst),
    .init  (crc_init),
    .feed  (crc_feed),
    .din   (sh_lsb),
    .shift (crc_shift),
    .msb   (crc_msb)
  );

  assign active = (state != ST_IDLE);

  always_comb begin
    unique case (state)
      ST_PRE:  bit_c = ~cnt_lsb;
      ST_SYNC: bit_c = 1'b1;
      ST_DATA: bit_c = sh_lsb;
      ST_FCS:  bit_c = ~crc_msb;
      ST_JAM:  bit_c = 1'b1;
      default: bit_c = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      txen_q  <= 1'b0;
      txd_q   <= 1'b0;
      done_q  <= 1'b0;
      under_q <= 1'b0;
    end else begin
      txen_q <= active;
      txd_q  <= active & bit_c;
      done_q <= !active && txen_q;
      if (crc_init)          under_q <= 1'b0;
      else if (underrun_set) under_q <= 1'b1;
    end
  end

  assign txen       = txen_q;
  assign txd        = txd_q;
  assign frame_done = done_q;
  assign underrun   = under_q;

endmodule

// File: rtl/eth_tx_framer_chk.sv
module eth_tx_framer_chk (
  input logic clk,
  input logic rst,
  input logic frame_start,
  input logic byte_empty,
  input logic byte_pop,
  input logic txen,
  input logic frame_done,
  input logic underrun
);

  // R7
  done_after_en_chk: assert property (@(posedge clk) disable iff (rst)
    frame_done |-> (!txen && $past(txen)));

  // R7
  done_single_chk: assert property (@(posedge clk) disable iff (rst)
    frame_done |=> !frame_done);

  // R2
  en_follows_start_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(txen) |-> $past(frame_start, 2));

  // R3
  pop_not_empty_chk: assert property (@(posedge clk) disable iff (rst)
    byte_pop |-> !byte_empty);

  // R3
  pop_in_frame_chk: assert property (@(posedge clk) disable iff (rst)
    byte_pop |-> txen);

  // R6
  underrun_in_frame_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(underrun) |-> txen);

endmodule

bind eth_tx_framer eth_tx_framer_chk u_chk (
  .clk         (clk),
  .rst         (rst),
  .frame_start (frame_start),
  .byte_empty  (byte_empty),
  .byte_pop    (byte_pop),
  .txen        (txen),
  .frame_done  (frame_done),
  .underrun    (underrun)
);

// File: tb/sim_eth_tx_framer.sv
`timescale 1ns/1ps
module sim_eth_tx_framer;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       frame_start = 1'b0;
  logic       collision = 1'b0;
  logic [7:0] byte_data;
  logic       byte_empty, byte_last, byte_pop;
  logic       txen, txd, frame_done, underrun;

  always #2.5 clk = ~clk;

  // byte queue model
  logic [7:0] mem [0:63];
  int n_bytes = 0;
  int avail   = 0;
  int rd_idx  = 0;
  logic clr   = 1'b0;

  assign byte_empty = (rd_idx >= avail);
  assign byte_data  = mem[rd_idx[5:0]];
  assign byte_last  = (rd_idx == n_bytes - 1);

  always @(posedge clk) begin
    if (clr) rd_idx <= 0;
    else if (byte_pop) rd_idx <= rd_idx + 1;
  end

  eth_tx_framer u0 (
    .clk(clk), .rst(rst), .frame_start(frame_start),
    .byte_data(byte_data), .byte_empty(byte_empty), .byte_last(byte_last),
    .byte_pop(byte_pop), .collision(collision), .txen(txen), .txd(txd),
    .frame_done(frame_done), .underrun(underrun)
  );

  // capture monitor
  logic cap [0:2047];
  logic expb [0:2047];
  int ncap = 0;
  int done_cnt = 0;
  int done_err = 0;
  logic prev_en = 1'b0;

  always @(negedge clk) begin
    if (clr) ncap = 0;
    else if (txen) begin
      if (ncap < 2048) cap[ncap] = txd;
      ncap++;
    end
    if (frame_done) begin
      done_cnt++;
      if (txen || !prev_en) done_err++;
    end
    prev_en = txen;
  end

  int nvec = 0;
  int nfail = 0;
  logic finished = 1'b0;

  task automatic chk(input string req, input logic ok,
                     input longint act, input longint exp);
    nvec++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] ref_fcs(input int nb);
    logic [31:0] r;
    logic fb;
    r = 32'hFFFF_FFFF;
    for (int b = 0; b < nb; b++)
      for (int k = 0; k < 8; k++) begin
        fb = r[0] ^ mem[b][k];
        r  = r >> 1;
        if (fb) r = r ^ 32'hEDB8_8320;
      end
    return ~r;
  endfunction

  task automatic build_exp(input int nb, input int av, input int ck,
                           output int len);
    int p;
    logic [31:0] f;
    p = 0;
    for (int i = 0; i < 62; i++) begin expb[p] = (i % 2 == 0); p++; end
    expb[p] = 1'b1; p++;
    expb[p] = 1'b1; p++;
    for (int b = 0; b < nb; b++)
      for (int k = 0; k < 8; k++) begin expb[p] = mem[b][k]; p++; end
    f = ref_fcs(nb);
    for (int k = 0; k < 32; k++) begin expb[p] = f[k]; p++; end
    len = p;
    if (ck >= 0) begin
      len = ck + 1 + 32;
      for (int i = ck + 1; i < len; i++) expb[i] = 1'b1;
    end else if (av < nb) begin
      len = 64 + 8 * av + 32;
      for (int i = 64 + 8 * av; i < len; i++) expb[i] = 1'b1;
    end
  endtask

  // One frame: ck = collision after that many bits seen, rs = restart attempt.
  task automatic run_frame(input string req, input int nb, input int av,
                           input int ck, input int rs, input logic exp_un);
    int seen, guard, base, len, bad, first_bad;
    n_bytes = nb;
    avail   = av;
    @(negedge clk); clr = 1'b1;
    @(negedge clk); clr = 1'b0;
    base = done_cnt;
    frame_start = 1'b1;
    seen = 0;
    guard = 0;
    while (done_cnt == base && guard < 4000) begin
      @(negedge clk);
      guard++;
      frame_start = 1'b0;
      collision   = 1'b0;
      if (txen) begin
        seen++;
        if (ck >= 0 && seen == ck) collision = 1'b1;
        if (rs >= 0 && seen == rs) frame_start = 1'b1;
      end
    end
    frame_start = 1'b0;
    collision   = 1'b0;
    repeat (3) @(negedge clk);
    build_exp(nb, av, ck, len);
    bad = 0;
    first_bad = -1;
    for (int i = 0; i < len && i < ncap; i++)
      if (cap[i] !== expb[i]) begin
        bad++;
        if (first_bad < 0) first_bad = i;
      end
    chk({req, " R7 one done pulse"}, (done_cnt - base) == 1, done_cnt - base, 1);
    chk({req, " R7 done after txen"}, done_err == 0, done_err, 0);
    chk({req, " frame length"}, ncap == len, ncap, len);
    chk({req, " bit stream (first bad index)"}, bad == 0, first_bad, -1);
    chk({req, " R6 underrun flag"}, underrun == exp_un, underrun, exp_un);
    if (ck < 0 && av >= nb)
      chk({req, " R3 bytes popped"}, rd_idx == nb, rd_idx, nb);
  endtask

  task automatic t_reset;
    chk("R1 txen", txen == 1'b0, txen, 0);
    chk("R1 txd", txd == 1'b0, txd, 0);
    chk("R1 done", frame_done == 1'b0, frame_done, 0);
    chk("R1 underrun", underrun == 1'b0, underrun, 0);
    chk("R1 pop", byte_pop == 1'b0, byte_pop, 0);
  endtask

  task automatic t_check_value;
    logic [31:0] w;
    for (int i = 0; i < 9; i++) mem[i] = 8'h31 + 8'(i);
    run_frame("R4 digits", 9, 9, -1, -1, 1'b0);
    for (int k = 0; k < 32; k++) w[k] = cap[64 + 72 + k];
    chk("R4 FCS word of 123456789", w == 32'hCBF4_3926, w, 32'hCBF4_3926);
    chk("R2 first preamble bits", cap[0] == 1'b1 && cap[1] == 1'b0,
        {cap[0], cap[1]}, 2'b10);
    chk("R2 sync bits", cap[62] == 1'b1 && cap[63] == 1'b1,
        {cap[62], cap[63]}, 2'b11);
  endtask

  task automatic t_patterns;
    mem[0] = 8'h00;
    run_frame("R3 one zero byte", 1, 1, -1, -1, 1'b0);
    for (int i = 0; i < 4; i++) mem[i] = 8'hFF;
    run_frame("R3 four ones bytes", 4, 4, -1, -1, 1'b0);
    for (int i = 0; i < 20; i++) mem[i] = 8'(i * 37 + 5);
    run_frame("R3 counting 20", 20, 20, -1, -1, 1'b0);
    for (int i = 0; i < 60; i++) mem[i] = 8'(i * i + 8'hA5) ^ 8'(i << 3);
    run_frame("R4 mixed 60", 60, 60, -1, -1, 1'b0);
  endtask

  task automatic t_collision;
    for (int i = 0; i < 20; i++) mem[i] = 8'(8'hC3 + i * 11);
    run_frame("R5 collision in data", 20, 20, 100, -1, 1'b0);
    run_frame("R5 collision in preamble", 20, 20, 10, -1, 1'b0);
    run_frame("R5 collision in FCS", 20, 20, 229, -1, 1'b0);
  endtask

  task automatic t_underrun;
    for (int i = 0; i < 6; i++) mem[i] = 8'(8'h5A + i);
    run_frame("R6 empty at first byte", 6, 0, -1, -1, 1'b1);
    run_frame("R6 empty mid packet", 6, 3, -1, -1, 1'b1);
  endtask

  task automatic t_ignore;
    int held;
    for (int i = 0; i < 8; i++) mem[i] = 8'(8'h10 + i * 3);
    run_frame("R8 restart while busy", 8, 8, -1, 40, 1'b0);
    held = ncap;
    repeat (80) @(negedge clk);
    chk("R8 no second frame", ncap == held && !txen, ncap, held);
    collision = 1'b1;
    repeat (5) @(negedge clk);
    collision = 1'b0;
    repeat (20) @(negedge clk);
    chk("R8 collision idle", ncap == held && !txen && !frame_done, ncap, held);
  endtask

  task automatic finish_run;
    if (!finished) begin
      finished = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nvec++;
    nfail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    for (int i = 0; i < 64; i++) mem[i] = 8'h00;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    t_reset();
    t_check_value();
    t_patterns();
    t_collision();
    t_underrun();
    t_ignore();
    finish_run();
  end

endmodule